// File: doc/BRIEF.md
# Fixed-Polarity External Interrupt Edge Detector

This block monitors eight asynchronous external pins and turns edges on them into latched interrupt requests for an interrupt controller. Each pin is synchronised, then compared with its value one clock earlier. Four lines react only to a rising level and the other four only to a falling level. The polarity is fixed by the line's position and cannot be programmed.

An 8-bit enable register is loaded through a single-cycle write port and can always be read back. A qualifying edge on an enabled line sets that line's pending flag. The flag stays set until the controller pulses that line's acknowledge bit, or until software clears the line's enable bit.

A global mask input holds back delivery of requests but not latching, so edges seen while masked are delivered once the mask drops. A combinational wake output compares the raw pins with their last synchronised level. It can therefore flag an enabled edge even while the clock is stopped in halt mode.

Top module: `pin_edge_irq`

## Requirements
- R1: While `rst_n` is low, the enable register, all pending flags, all request outputs and the readback value are zero.
- R2: A cycle with `en_we_i` high loads `en_wdata_i` into the enable register. The new value appears on `en_rdata_o` after that clock edge.
- R3: Bit positions 0, 1, 4 and 5 (lines 1, 2, 5, 6) are rising-edge lines. A low-to-high change on such a pin, applied before clock edge k, sets its pending bit at edge k+2. The bit is still clear after edge k+1.
- R4: Bit positions 2, 3, 6 and 7 (lines 3, 4, 7, 8) are falling-edge lines. A high-to-low change on such a pin sets its pending bit with the same three-edge latency as R3.
- R5: A transition in the opposite direction on any line (falling on a rising line, rising on a falling line) leaves its pending bit unchanged.
- R6: An edge on a line whose enable bit is 0 is not latched, and it does not appear later when the bit is set again.
- R7: A pending bit is never set while its enable bit is 0. A write that clears an enable bit clears that line's pending bit at the same clock edge.
- R8: A pending bit with its `ack_i` bit high at a clock edge is cleared at that edge. If a new qualifying edge on that line coincides with the acknowledge, the bit stays set.
- R9: `irq_o` equals `pend_o` while `gmask_i` is 0 and is all zeros while `gmask_i` is 1. Pending bits are kept while masked.
- R10: `wake_o` is high whenever any pending bit is set. It is also high, with no clock edge needed, when the raw pin of an enabled line has moved to its active level relative to the line's synchronised level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Raw asynchronous external pins, bit i is line i+1 |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register readback |
| gmask_i | input | 1 | Global interrupt mask from the core, 1 blocks delivery |
| ack_i | input | 8 | Per-line acknowledge pulses that clear pending flags |
| pend_o | output | 8 | Latched pending flags |
| irq_o | output | 8 | Requests delivered to the interrupt controller |
| wake_o | output | 1 | Halt-mode wake indication |

## Verification
The bench targets an acknowledge that lands in the same cycle as a fresh edge. A design that lets the clear win would silently lose that interrupt.

It also checks:
- Wrong-direction edges on both line groups. A polarity map that is swapped or mirrored would set flags on those edges.
- Edges that arrive while the line is disabled. Letting them through would produce spurious requests once the line is enabled again.
- Requests raised while masked. Dropping these would lose interrupts taken under a mask.
- The exact three-edge latency. An extra or missing synchroniser stage shifts the cycle in which a flag sets.
- The wake output, sampled before any clock edge. A registered wake would stay low there and leave a halted core asleep.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int unsigned PEI_LINES = 8;
  // 1 = rising-edge line, 0 = falling-edge line; bit i is line i+1
  localparam logic [PEI_LINES-1:0] PEI_RISE_MAP = 8'b0011_0011;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } pei_pol_e;

  function automatic pei_pol_e pei_line_pol(input logic [PEI_LINES-1:0] map, input int idx);
    return map[idx] ? POL_RISE : POL_FALL;
  endfunction
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_n;

  always_comb begin
    chain_n[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_n[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/pei_edge.sv
module pei_edge
  import pei_pkg::*;
#(
  parameter int unsigned    W        = 8,
  parameter logic [W-1:0]   RISE_MAP = 8'b0011_0011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] raw_hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    if (pei_line_pol(RISE_MAP, i) == POL_RISE) begin : g_rise
      assign edge_o[i]    = lvl_i[i] & ~prev_q[i];
      assign raw_hit_o[i] = raw_i[i] & ~lvl_i[i];
    end else begin : g_fall
      assign edge_o[i]    = ~lvl_i[i] & prev_q[i];
      assign raw_hit_o[i] = ~raw_i[i] & lvl_i[i];
    end
  end
endmodule

// File: rtl/pei_pend.sv
module pei_pend #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_n;
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_n;

  always_comb begin
    en_n   = we_i ? wdata_i : en_q;
    pend_n = ((pend_q & ~ack_i) | (edge_i & en_q)) & en_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we_i) begin
      en_q <= en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_n;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pei_pkg::*;
#(
  parameter int unsigned            NUM_LINES   = PEI_LINES,
  parameter int unsigned            SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0]   RISE_MAP    = PEI_RISE_MAP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic                 en_we_i,
  input  logic [NUM_LINES-1:0] en_wdata_i,
  output logic [NUM_LINES-1:0] en_rdata_o,
  input  logic                 gmask_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic                 wake_o
);
  logic [NUM_LINES-1:0] lvl_w;
  logic [NUM_LINES-1:0] edge_w;
  logic [NUM_LINES-1:0] raw_hit_w;
  logic [NUM_LINES-1:0] en_w;
  logic [NUM_LINES-1:0] pend_w;

  pei_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (lvl_w)
  );

  pei_edge #(.W(NUM_LINES), .RISE_MAP(RISE_MAP)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl_w),
    .raw_i     (pins_i),
    .edge_o    (edge_w),
    .raw_hit_o (raw_hit_w)
  );

  pei_pend #(.W(NUM_LINES)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (en_we_i),
    .wdata_i (en_wdata_i),
    .edge_i  (edge_w),
    .ack_i   (ack_i),
    .en_o    (en_w),
    .pend_o  (pend_w)
  );

  assign en_rdata_o = en_w;
  assign pend_o     = pend_w;
  assign irq_o      = pend_w & {NUM_LINES{~gmask_i}};
  assign wake_o     = (|pend_w) | (|(raw_hit_w & en_w));
endmodule

// File: rtl/pei_chk.sv
module pei_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_we_i,
  input logic [W-1:0] en_wdata_i,
  input logic [W-1:0] en_rdata_o,
  input logic         gmask_i,
  input logic [W-1:0] ack_i,
  input logic [W-1:0] edge_i,
  input logic [W-1:0] pend_o,
  input logic [W-1:0] irq_o,
  input logic         wake_o
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (pend_o == '0 && en_rdata_o == '0 && irq_o == '0);
    end
  end

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> en_rdata_o == $past(en_wdata_i));

  // R7
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~en_rdata_o) == '0);

  // R9
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_i |-> irq_o == '0);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_o & $past(ack_i & ~edge_i)) == '0);

  // R6
  no_disabled_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_o & ~$past(pend_o) & ~$past(edge_i & en_rdata_o)) == '0);

  // R10
  wake_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_o) |-> wake_o);
endmodule

bind pin_edge_irq pei_chk #(.W(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_we_i    (en_we_i),
  .en_wdata_i (en_wdata_i),
  .en_rdata_o (en_rdata_o),
  .gmask_i    (gmask_i),
  .ack_i      (ack_i),
  .edge_i     (edge_w),
  .pend_o     (pend_o),
  .irq_o      (irq_o),
  .wake_o     (wake_o)
);

// File: tb/pin_edge_irq_tb.sv
module pin_edge_irq_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] RISE = 8'b0011_0011;

  logic       clk;
  logic       rst_n;
  logic [7:0] pins;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       gmask;
  logic [7:0] ack;
  logic [7:0] pend;
  logic [7:0] irq;
  logic       wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pin_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .en_we_i(we), .en_wdata_i(wdata),
    .en_rdata_o(rdata), .gmask_i(gmask), .ack_i(ack), .pend_o(pend),
    .irq_o(irq), .wake_o(wake)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: history queue of sampled pins, enable and pending words
  logic [7:0] hist[$];
  logic [7:0] m_en;
  logic [7:0] m_pend;

  task automatic model_reset();
    hist   = {8'h00, 8'h00, 8'h00};
    m_en   = 8'h00;
    m_pend = 8'h00;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      logic [7:0] cur, old, hit, en_next;
      cur = hist[1];
      old = hist[2];
      hit = 8'h00;
      for (int i = 0; i < 8; i++) begin
        if (RISE[i]) hit[i] = cur[i] && !old[i];
        else         hit[i] = !cur[i] && old[i];
      end
      en_next = we ? wdata : m_en;
      m_pend  = ((m_pend & ~ack) | (hit & m_en)) & en_next;
      m_en    = en_next;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic model_wake();
    logic [7:0] h;
    h = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (RISE[i]) h[i] = pins[i] && !hist[1][i];
      else         h[i] = !pins[i] && hist[1][i];
    end
    return (|m_pend) || (|(h & m_en));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from both edges
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("R2 model en_rdata", rdata, m_en);
      chk("R3/R4 model pend", pend, m_pend);
      chk("R9 model irq", irq, gmask ? 8'h00 : m_pend);
      chk("R10 model wake", {7'd0, wake}, {7'd0, model_wake()});
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_en(input logic [7:0] v);
    we = 1'b1; wdata = v;
    step(1);
    we = 1'b0;
  endtask

  task automatic finish_tb();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_tb();
  end

  initial begin
    pins = 8'h00; we = 1'b0; wdata = 8'h00; gmask = 1'b0; ack = 8'h00;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    step(3);
    // R1 reset state
    chk("R1 pend", pend, 8'h00);
    chk("R1 irq", irq, 8'h00);
    chk("R1 en_rdata", rdata, 8'h00);
    rst_n = 1'b1;
    step(2);

    // R2 write and readback
    wr_en(8'hFF);
    chk("R2 readback", rdata, 8'hFF);

    // R3 rising line latency
    pins[0] = 1'b1;
    step(2);
    chk("R3 not yet", pend & 8'h01, 8'h00);
    step(1);
    chk("R3 rise latched", pend & 8'h01, 8'h01);
    ack = 8'h01; step(1); ack = 8'h00;
    chk("R8 ack clears", pend & 8'h01, 8'h00);

    // R5 rising pin on a falling line is ignored
    pins[2] = 1'b1;
    step(4);
    chk("R5 rise on falling line", pend & 8'h04, 8'h00);
    // R4 falling line
    pins[2] = 1'b0;
    step(2);
    chk("R4 not yet", pend & 8'h04, 8'h00);
    step(1);
    chk("R4 fall latched", pend & 8'h04, 8'h04);
    // R5 falling pin on a rising line is ignored
    pins[0] = 1'b0;
    step(4);
    chk("R5 fall on rising line", pend & 8'h01, 8'h00);

    // R9 masking holds requests back but keeps them pending
    gmask = 1'b1; step(1);
    chk("R9 masked irq", irq, 8'h00);
    chk("R9 kept pending", pend & 8'h04, 8'h04);
    gmask = 1'b0; step(1);
    chk("R9 delivered", irq & 8'h04, 8'h04);

    // R8 acknowledge coinciding with a new edge
    pins[1] = 1'b1; step(3);
    chk("R8 line2 set", pend & 8'h02, 8'h02);
    pins[1] = 1'b0; step(3);
    pins[1] = 1'b1; step(2);
    ack = 8'h02; step(1); ack = 8'h00;
    chk("R8 edge beats ack", pend & 8'h02, 8'h02);
    ack = 8'h02; step(1); ack = 8'h00;
    chk("R8 plain ack", pend & 8'h02, 8'h00);

    // R6 disabled line does not latch, even after re-enable
    wr_en(8'hFE);
    pins[0] = 1'b1; step(4);
    chk("R6 disabled", pend & 8'h01, 8'h00);
    wr_en(8'hFF); step(2);
    chk("R6 after re-enable", pend & 8'h01, 8'h00);
    pins[0] = 1'b0; step(3);

    // R7 clearing an enable bit drops the pending flag at once
    wr_en(8'hFB);
    chk("R7 pend dropped", pend & 8'h04, 8'h00);
    chk("R7 irq dropped", irq & 8'h04, 8'h00);
    wr_en(8'hFF);

    // R10 wake without a clock edge
    ack = 8'hFF; step(1); ack = 8'h00;
    step(1);
    chk("R10 idle wake", {7'd0, wake}, 8'h00);
    pins[4] = 1'b1;
    #1;
    chk("R10 raw wake", {7'd0, wake}, 8'h01);
    step(4);
    chk("R10 pending wake", {7'd0, wake}, 8'h01);
    ack = 8'hFF; step(1); ack = 8'h00;

    // mixed traffic against the reference
    for (int c = 0; c < 600; c++) begin
      if (($urandom % 4) == 0) pins[$urandom % 8] ^= 1'b1;
      ack   = 8'($urandom & $urandom & $urandom);
      gmask = (($urandom % 8) == 0);
      we    = (($urandom % 20) == 0);
      wdata = 8'($urandom) | 8'h81;
      step(1);
    end
    we = 1'b0;
    step(2);
    finish_tb();
  end
endmodule